// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins a host-side data line to a card-side data line. Both lines are wired-AND: each rests high through a pull-up and any party may pull it low. The block watches both lines. The side whose line falls first becomes the master. After a programmable edge delay the block pulls the other side, the slave, low. This carries the master's logic 0 across the gap.

When the master line goes high again, the block releases the slave drive. In the same cycle it starts a timed active pull-up pulse on the slave side, so the slave line rises quickly. The block then waits until both lines read high before it accepts a new transfer. While a transfer is in progress, falling edges are ignored. This lockout stops the block's own low on the slave line from coming back as a fresh request.

Each side is modelled with three signals, all in the system clock domain:
- an input sample of the line;
- an active-low drive enable;
- an active-high pull-up pulse enable.

One top instance holds a parameterised number of identical lanes. The default is three data lines.

Top module: `oc_line_repeater`

## Requirements
- R1: While reset is applied and after it, every lane is idle: all `*_drive_n` bits read 1 and all `*_pu_en` bits read 0.
- R2: The side whose line falls first becomes master. Only the opposite (slave) side is ever driven low, and the two sides of a lane are never driven low together.
- R3: Once a transfer starts, falling edges on either line of that lane are ignored until the lane is idle again. In particular, a low on the slave line never drives the master side.
- R4: The slave drive goes low exactly 3+EDGE_DLY cycles after the master line first reads low at the input. This counts two synchroniser stages and one edge register. The drive stays low until the master line is seen high.
- R5: The slave drive is released exactly 3 cycles after the master line returns high. In that same cycle the slave pull-up enable rises, and it stays high for exactly PU_LEN cycles.
- R6: After the pull-up pulse, the lane waits until both synchronised lines read high. Only then does it re-arm edge detection. A falling edge seen after that starts a new transfer.
- R7: If both lines show a falling edge in the same cycle, the host side becomes master and the card side is driven.
- R8: Lanes are independent. Activity on one lane changes no output bit of another lane.
- R9: On either side, the drive enable and the pull-up enable are never active in the same cycle.
- R10: If the master line returns high before the edge delay has elapsed, the lane drives neither side and issues no pull-up pulse. It then returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_in | input | NLINES | Sampled level of each host-side line |
| card_in | input | NLINES | Sampled level of each card-side line |
| host_drive_n | output | NLINES | Active-low enable pulling the host line low |
| card_drive_n | output | NLINES | Active-low enable pulling the card line low |
| host_pu_en | output | NLINES | Active pull-up pulse enable on the host line |
| card_pu_en | output | NLINES | Active pull-up pulse enable on the card line |

## Verification
The bench models each line as a wired-AND of an external pull and the block's own drive. It runs a behavioural reference that is compared on every clock. The stimulus patterns are:
- a host-led transfer, which fixes the R4 and R5 latencies;
- a card-led transfer, which shows that the direction is chosen dynamically;
- a simultaneous fall, which separates the tie rule from plain first-come election;
- a glitch shorter than the edge delay, which separates abort from drive;
- late extra falls on both lines during a transfer and during recovery, which separate a working lockout from an echo loop;
- a transfer on a single lane, which confirms that the other lanes stay untouched.

// File: rtl/oclr_pkg.sv
// Package: shared types for the line repeater.
// Assumes: nothing beyond IEEE 1800-2017.
package oclr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_DELAY   = 3'd1,
        ST_DRIVE   = 3'd2,
        ST_PULLUP  = 3'd3,
        ST_RECOVER = 3'd4
    } lane_state_t;

    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_CARD = 1'b1
    } side_t;
endpackage

// File: rtl/oclr_sync.sv
// Module: oclr_sync
// Purpose: two-flop synchroniser for a vector of line samples.
// Assumes: an idle line reads high, so reset loads ones.
module oclr_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    // Two register stages; reset to the idle-high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '1;
            q      <= '1;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/oclr_fall_det.sv
// Module: oclr_fall_det
// Purpose: reports a high-to-low step on a synchronised line, gated by arm.
// Assumes: line_s is already synchronous; arm is high only while the lane idles.
module oclr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic line_s,
    input  logic arm,
    output logic fall
);
    logic prev;

    // Remember the previous level; idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= line_s;
    end

    // A fall is reported only while armed (lockout otherwise).
    always_comb fall = arm & prev & ~line_s;
endmodule

// File: rtl/oclr_lane_fsm.sv
// Module: oclr_lane_fsm
// Purpose: master election, delayed slave drive, timed pull-up and recovery
//          for one lane.
// Assumes: EDGE_DLY >= 1 and PU_LEN >= 1; inputs are synchronised.
module oclr_lane_fsm
    import oclr_pkg::*;
#(
    parameter int EDGE_DLY = 2,
    parameter int PU_LEN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_s,
    input  logic card_s,
    input  logic host_fall,
    input  logic card_fall,
    output logic armed,
    output logic host_drive_n,
    output logic card_drive_n,
    output logic host_pu_en,
    output logic card_pu_en
);
    localparam int MAXC = (EDGE_DLY > PU_LEN) ? EDGE_DLY : PU_LEN;
    localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
    localparam logic [CW-1:0] DLY_LAST = CW'(EDGE_DLY - 1);
    localparam logic [CW-1:0] PU_LAST  = CW'(PU_LEN - 1);

    lane_state_t      state;
    side_t            master;
    logic [CW-1:0]    cnt;
    logic             master_s;

    // Level of the line currently acting as master.
    always_comb master_s = (master == SIDE_HOST) ? host_s : card_s;

    // Lane state sequencing with shared cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            master <= SIDE_HOST;
            cnt    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (host_fall) begin
                        master <= SIDE_HOST;
                        state  <= ST_DELAY;
                    end else if (card_fall) begin
                        master <= SIDE_CARD;
                        state  <= ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (master_s) begin
                        state <= ST_RECOVER;
                        cnt   <= '0;
                    end else if (cnt == DLY_LAST) begin
                        state <= ST_DRIVE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DRIVE: begin
                    if (master_s) begin
                        state <= ST_PULLUP;
                        cnt   <= '0;
                    end
                end
                ST_PULLUP: begin
                    if (cnt == PU_LAST) begin
                        state <= ST_RECOVER;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RECOVER: begin
                    if (host_s && card_s) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Decode slave-side enables from state and master.
    always_comb begin
        armed        = (state == ST_IDLE);
        host_drive_n = !((state == ST_DRIVE)  && (master == SIDE_CARD));
        card_drive_n = !((state == ST_DRIVE)  && (master == SIDE_HOST));
        host_pu_en   =   (state == ST_PULLUP) && (master == SIDE_CARD);
        card_pu_en   =   (state == ST_PULLUP) && (master == SIDE_HOST);
    end
endmodule

// File: rtl/oclr_lane.sv
// Module: oclr_lane
// Purpose: one complete lane: synchronisers, fall detectors, control FSM.
// Assumes: raw line levels may be asynchronous to clk.
module oclr_lane #(
    parameter int EDGE_DLY = 2,
    parameter int PU_LEN   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_raw,
    input  logic card_raw,
    output logic host_drive_n,
    output logic card_drive_n,
    output logic host_pu_en,
    output logic card_pu_en
);
    logic [1:0] lines_s;
    logic       host_fall;
    logic       card_fall;
    logic       armed;

    oclr_sync #(.WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({card_raw, host_raw}),
        .q     (lines_s)
    );

    oclr_fall_det u_fall_host (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_s (lines_s[0]),
        .arm    (armed),
        .fall   (host_fall)
    );

    oclr_fall_det u_fall_card (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_s (lines_s[1]),
        .arm    (armed),
        .fall   (card_fall)
    );

    oclr_lane_fsm #(.EDGE_DLY(EDGE_DLY), .PU_LEN(PU_LEN)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_s       (lines_s[0]),
        .card_s       (lines_s[1]),
        .host_fall    (host_fall),
        .card_fall    (card_fall),
        .armed        (armed),
        .host_drive_n (host_drive_n),
        .card_drive_n (card_drive_n),
        .host_pu_en   (host_pu_en),
        .card_pu_en   (card_pu_en)
    );
endmodule

// File: rtl/oc_line_repeater.sv
// Module: oc_line_repeater
// Purpose: NLINES identical bidirectional open-drain line repeater lanes.
// Assumes: one system clock; lines idle high through external pull-ups.
module oc_line_repeater #(
    parameter int NLINES   = 3,
    parameter int EDGE_DLY = 2,
    parameter int PU_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] host_in,
    input  logic [NLINES-1:0] card_in,
    output logic [NLINES-1:0] host_drive_n,
    output logic [NLINES-1:0] card_drive_n,
    output logic [NLINES-1:0] host_pu_en,
    output logic [NLINES-1:0] card_pu_en
);
    // One lane per data line.
    for (genvar g = 0; g < NLINES; g++) begin : g_lane
        oclr_lane #(.EDGE_DLY(EDGE_DLY), .PU_LEN(PU_LEN)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .host_raw     (host_in[g]),
            .card_raw     (card_in[g]),
            .host_drive_n (host_drive_n[g]),
            .card_drive_n (card_drive_n[g]),
            .host_pu_en   (host_pu_en[g]),
            .card_pu_en   (card_pu_en[g])
        );
    end
endmodule

// File: rtl/oclr_checker.sv
// Module: oclr_checker
// Purpose: temporal properties on the repeater ports, bound to the top.
// Assumes: attached via bind; observes ports only.
module oclr_checker #(
    parameter int NLINES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NLINES-1:0] host_in,
    input logic [NLINES-1:0] card_in,
    input logic [NLINES-1:0] host_drive_n,
    input logic [NLINES-1:0] card_drive_n,
    input logic [NLINES-1:0] host_pu_en,
    input logic [NLINES-1:0] card_pu_en
);
    for (genvar g = 0; g < NLINES; g++) begin : g_chk
        // R9: drive and pull-up never together on one side
        p_excl_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(!host_drive_n[g] && host_pu_en[g]));
        p_excl_card_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(!card_drive_n[g] && card_pu_en[g]));
        // R2: never both sides of a lane driven low
        p_one_side_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(!host_drive_n[g] && !card_drive_n[g]));
        // R5: the slave drive ends only into a pull-up pulse
        p_release_card_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(card_drive_n[g]) |-> card_pu_en[g]);
        p_release_host_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(host_drive_n[g]) |-> host_pu_en[g]);
        // R5: a pull-up pulse only follows a slave drive
        p_pu_after_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(card_pu_en[g]) |-> $past(!card_drive_n[g]));
        // R4: the card drive starts only while the host line was low
        p_drive_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(card_drive_n[g]) |-> !$past(host_in[g], 2));
        p_drive_cause_host_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(host_drive_n[g]) |-> !$past(card_in[g], 2));
    end
endmodule

bind oc_line_repeater oclr_checker #(.NLINES(NLINES)) u_oclr_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_in      (host_in),
    .card_in      (card_in),
    .host_drive_n (host_drive_n),
    .card_drive_n (card_drive_n),
    .host_pu_en   (host_pu_en),
    .card_pu_en   (card_pu_en)
);

// File: tb/test_oc_line_repeater.sv
module test_oc_line_repeater;
    localparam int N  = 3;
    localparam int ED = 2;
    localparam int PL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] host_pull = '0;
    logic [N-1:0] card_pull = '0;
    logic [N-1:0] host_line, card_line;
    logic [N-1:0] host_drive_n, card_drive_n, host_pu_en, card_pu_en;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    // Wired-AND lines: low if the outside pulls or the block drives.
    assign host_line = ~(host_pull | ~host_drive_n);
    assign card_line = ~(card_pull | ~card_drive_n);

    oc_line_repeater #(.NLINES(N), .EDGE_DLY(ED), .PU_LEN(PL)) i_oc_line_repeater (
        .clk(clk), .rst_n(rst_n), .host_in(host_line), .card_in(card_line),
        .host_drive_n(host_drive_n), .card_drive_n(card_drive_n),
        .host_pu_en(host_pu_en), .card_pu_en(card_pu_en)
    );

    // ---------------- behavioural reference ----------------
    // phase: 0 idle, 1 waiting, 2 passing low, 3 pulse, 4 settle
    int ph[N], who[N], tm[N];
    int hq[N][$], cq[N][$];
    int hprev[N], cprev[N];

    function automatic int m_hdrv(int l); return (ph[l] == 2 && who[l] == 1) ? 0 : 1; endfunction
    function automatic int m_cdrv(int l); return (ph[l] == 2 && who[l] == 0) ? 0 : 1; endfunction
    function automatic int m_hpu(int l);  return (ph[l] == 3 && who[l] == 1) ? 1 : 0; endfunction
    function automatic int m_cpu(int l);  return (ph[l] == 3 && who[l] == 0) ? 1 : 0; endfunction

    task automatic model_reset();
        for (int l = 0; l < N; l++) begin
            ph[l] = 0; who[l] = 0; tm[l] = 0;
            hq[l] = '{1, 1}; cq[l] = '{1, 1};
            hprev[l] = 1; cprev[l] = 1;
        end
    endtask

    task automatic model_step();
        for (int l = 0; l < N; l++) begin
            int hraw, craw, hs, cs, ms;
            hraw = (host_pull[l] || m_hdrv(l) == 0) ? 0 : 1;
            craw = (card_pull[l] || m_cdrv(l) == 0) ? 0 : 1;
            hs = hq[l][1]; cs = cq[l][1];
            ms = (who[l] == 0) ? hs : cs;
            case (ph[l])
                0: if (hprev[l] == 1 && hs == 0) begin ph[l] = 1; who[l] = 0; tm[l] = 0; end
                   else if (cprev[l] == 1 && cs == 0) begin ph[l] = 1; who[l] = 1; tm[l] = 0; end
                1: if (ms == 1) ph[l] = 4;
                   else begin tm[l]++; if (tm[l] >= ED) begin ph[l] = 2; tm[l] = 0; end end
                2: if (ms == 1) begin ph[l] = 3; tm[l] = 0; end
                3: begin tm[l]++; if (tm[l] >= PL) begin ph[l] = 4; tm[l] = 0; end end
                default: if (hs == 1 && cs == 1) ph[l] = 0;
            endcase
            hprev[l] = hs; cprev[l] = cs;
            hq[l].push_front(hraw); void'(hq[l].pop_back());
            cq[l].push_front(craw); void'(cq[l].pop_back());
        end
    endtask

    // Per-clock comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) model_reset();
        else begin
            model_step();
            for (int l = 0; l < N; l++) begin
                tests++;
                if (host_drive_n[l] !== 1'(m_hdrv(l)) || card_drive_n[l] !== 1'(m_cdrv(l))) begin
                    fails++;
                    $display("FAIL R4 lane %0d drive_n h/c actual %b/%b expected %0d/%0d",
                             l, host_drive_n[l], card_drive_n[l], m_hdrv(l), m_cdrv(l));
                end
                if (host_pu_en[l] !== 1'(m_hpu(l)) || card_pu_en[l] !== 1'(m_cpu(l))) begin
                    fails++;
                    $display("FAIL R5 lane %0d pu_en h/c actual %b/%b expected %0d/%0d",
                             l, host_pu_en[l], card_pu_en[l], m_hpu(l), m_cpu(l));
                end
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic tick(); @(negedge clk); #1; endtask

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Cycles until the given active-low drive falls.
    task automatic wait_drive(int card_side, int l, output int n);
        n = 0;
        do begin
            tick(); n++;
        end while (((card_side ? card_drive_n[l] : host_drive_n[l]) == 1'b1) && n < 40);
    endtask

    // Cycles until the given pull-up enable rises, then its width.
    task automatic wait_pu(int card_side, int l, output int lat, output int w);
        lat = 0; w = 0;
        do begin
            tick(); lat++;
        end while (((card_side ? card_pu_en[l] : host_pu_en[l]) == 1'b0) && lat < 40);
        while ((card_side ? card_pu_en[l] : host_pu_en[l]) == 1'b1 && w < 40) begin
            tick(); w++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n, lat, w, bad;
        model_reset();
        repeat (3) tick();
        // R1: idle outputs during reset
        check("R1 drive_n during reset", int'(&host_drive_n & &card_drive_n), 1);
        rst_n = 1'b1;
        repeat (3) tick();
        check("R1 pu_en after reset", int'(|host_pu_en | |card_pu_en), 0);
        check("R1 drive_n after reset", int'(&host_drive_n & &card_drive_n), 1);

        // R2/R4: host-led transfer on lane 0
        host_pull[0] = 1'b1;
        wait_drive(1, 0, n);
        check("R4 card drive latency", n, 3 + ED);
        check("R2 host side not driven", int'(host_drive_n[0]), 1);
        // R3: card line echo pulled externally during the transfer
        bad = 0;
        card_pull[0] = 1'b1;
        repeat (4) begin tick(); if (!host_drive_n[0]) bad++; end
        card_pull[0] = 1'b0;
        repeat (2) begin tick(); if (!host_drive_n[0]) bad++; end
        check("R3 no drive of master during lockout", bad, 0);
        // R5: release
        host_pull[0] = 1'b0;
        wait_pu(1, 0, lat, w);
        check("R5 release latency", lat, 3);
        check("R5 pull-up width", w, PL);
        repeat (4) tick();
        check("R6 idle after recovery", int'(card_drive_n[0] & host_drive_n[0]), 1);

        // R2: card-led transfer on lane 0
        card_pull[0] = 1'b1;
        wait_drive(0, 0, n);
        check("R2 host drive latency card master", n, 3 + ED);
        check("R2 card side not driven", int'(card_drive_n[0]), 1);
        // R6: host stays low beyond the pulse -> wait in recovery
        host_pull[0] = 1'b1;
        card_pull[0] = 1'b0;
        bad = 0;
        repeat (12) begin tick(); if (!card_drive_n[0]) bad++; end
        check("R6 no new transfer while lines low", bad, 0);
        host_pull[0] = 1'b0;
        repeat (6) tick();
        card_pull[0] = 1'b1;
        wait_drive(0, 0, n);
        check("R6 re-armed transfer served", n, 3 + ED);
        card_pull[0] = 1'b0;
        repeat (15) tick();

        // R7: simultaneous fall on lane 1
        host_pull[1] = 1'b1; card_pull[1] = 1'b1;
        wait_drive(1, 1, n);
        check("R7 tie gives host mastership", n, 3 + ED);
        check("R7 host side not driven", int'(host_drive_n[1]), 1);
        // R8: other lanes untouched
        check("R8 lane 0 idle", int'(host_drive_n[0] & card_drive_n[0] & ~host_pu_en[0] & ~card_pu_en[0]), 1);
        check("R8 lane 2 idle", int'(host_drive_n[2] & card_drive_n[2] & ~host_pu_en[2] & ~card_pu_en[2]), 1);
        host_pull[1] = 1'b0; card_pull[1] = 1'b0;
        repeat (15) tick();

        // R10: glitch shorter than the edge delay on lane 2
        host_pull[2] = 1'b1;
        tick();
        host_pull[2] = 1'b0;
        bad = 0;
        repeat (12) begin tick(); if (!card_drive_n[2] || card_pu_en[2]) bad++; end
        check("R10 short glitch no drive or pulse", bad, 0);
        // R9: after a full transfer on lane 2, enables stay exclusive
        card_pull[2] = 1'b1;
        bad = 0;
        repeat (8) begin tick(); if (!host_drive_n[2] && host_pu_en[2]) bad++; end
        card_pull[2] = 1'b0;
        repeat (10) begin tick(); if (!host_drive_n[2] && host_pu_en[2]) bad++; end
        check("R9 drive and pull-up exclusive", bad, 0);

        repeat (5) tick();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule